// File: doc/BRIEF.md
# Serial Control Register Port

This block is a write-only control port for a bank of 9-bit configuration registers. A host sends 16-bit words; the upper seven bits name a register and the lower nine bits are the value. One static pin picks the wire protocol. With the pin low, the block takes a three-line format: a shift clock, a data line and a latch strobe. With the pin high, it acts as a two-wire bus target that answers to one fixed device address, and an external pull-up forms the open-drain data line. All serial lines are sampled with the system clock after two synchronizer stages.

Some registers are grouped as left/right volume pairs. A write to a pair member only loads a hidden shadow copy. The visible values of both members change together, and only when a word to either member carries the update flag. The update flag can instead ask the block to wait for a zero crossing. If no crossing comes, a timeout applies the change after one to two timeout periods. A write of any value to register 0 returns the whole bank to its parameterised defaults.

Top module: `serctl_regfile`

## Requirements
- R1: In three-wire mode (mode_two_wire=0), while sle is low each rising edge of sck shifts sdi in, MSB first. The rising edge of sle commits the word: bits 15:9 are the register address and bits 8:0 are the data. A plain (non-volume) register shows the data on reg_q at bits [9*addr +: 9].
- R2: In three-wire mode, a frame with fewer or more than 16 sck rising edges between the fall and the rise of sle changes no register.
- R3: In two-wire mode (mode_two_wire=1), a start condition is followed by an address byte of 0011010 plus a write bit of 0, then the data high byte (word bits 15:8), then the data low byte (bits 7:0). The block acknowledges each of the three bytes by pulling the data line low during the ninth clock. The word is committed after the low byte.
- R4: In two-wire mode, an address byte with a different 7-bit address, or with the read bit set, gets no acknowledge, and the data bytes that follow change no register.
- R5: In three-wire mode, two-wire traffic changes nothing and sda_pull stays 0. In two-wire mode, a three-wire frame changes nothing.
- R6: A committed word to address 0 sets every register and every shadow copy to its default and cancels every pending volume update.
- R7: A word to a volume-pair register with data bit 8 = 0 leaves reg_q unchanged.
- R8: A word to a pair register with bit 8 = 1 and bit 7 = 0 copies both shadow values of the pair to reg_q within a few cycles. Each copied value has bit 8 read as 0. upd_stb for that pair pulses high for one cycle in the cycle the new values appear.
- R9: With bit 8 = 1 and bit 7 = 1, the pair waits and is applied on the clock edge that samples its zc_in bit high.
- R10: If a zero-crossing-gated update sees no crossing, it is applied no earlier than TMO_CYC cycles and no later than 2*TMO_CYC+8 cycles after the rise of sle.
- R11: Words to addresses at or above NREG change no register.
- R12: After rst_n, reg_q holds the RST_VALS parameter, upd_stb is 0 and sda_pull is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_two_wire | input | 1 | 0 selects three-wire format, 1 selects two-wire bus |
| sck | input | 1 | Serial clock (both modes) |
| sdi | input | 1 | Serial data; in two-wire mode the resolved bus level |
| sle | input | 1 | Three-wire latch strobe, commit on rising edge |
| zc_in | input | NPAIR | Zero-crossing indication, one bit per volume pair |
| sda_pull | output | 1 | Drive the two-wire data line low (acknowledge) |
| upd_stb | output | NPAIR | One-cycle pulse when a pair's values are applied |
| reg_q | output | 9*NREG | Visible register values, register i at [9*i +: 9] |

## Verification
A corrupt shift counter or protocol state shows up at the ports within one frame. Either a register fails to change after a valid frame, a malformed frame changes one, or the acknowledge slot is missing or extra on the very next byte. A shadow or pending flag that is out of step stays hidden until the next update request or zero crossing. At that point the pair changes early, late, partly or not at all, so the bench checks pair values both before and after each trigger and measures the timeout latency against its window. A soft reset that leaves a request pending shows up as a stray strobe after a later crossing.

// File: rtl/serctl_regfile.sv
`timescale 1ns/1ps
module serctl_regfile #(
  parameter int NREG = 16,
  parameter int NPAIR = 2,
  parameter int TMO_CYC = 1024,
  parameter logic [6:0] DEV_ADDR = 7'b0011010,
  parameter logic [NPAIR*14-1:0] PAIR_MAP = {7'd7, 7'd6, 7'd5, 7'd4},
  parameter logic [NREG*9-1:0] RST_VALS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_two_wire,
  input  logic              sck,
  input  logic              sdi,
  input  logic              sle,
  input  logic [NPAIR-1:0]  zc_in,
  output logic              sda_pull,
  output logic [NPAIR-1:0]  upd_stb,
  output logic [NREG*9-1:0] reg_q
);
  localparam int AW = $clog2(NREG);
  localparam int TW = $clog2(TMO_CYC + 1);

  typedef enum logic [2:0] {I_IDLE, I_ADDR, I_ACKA, I_HI, I_ACKH, I_LO, I_ACKL, I_SKIP} ist_t;

  // two synchronizer stages plus one history stage per line
  logic [2:0] sck_p, sdi_p, sle_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= 3'b000;
      sdi_p <= 3'b111;
      sle_p <= 3'b111;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      sdi_p <= {sdi_p[1:0], sdi};
      sle_p <= {sle_p[1:0], sle};
    end

  wire sck_r   = sck_p[1] & ~sck_p[2];
  wire sck_f   = ~sck_p[1] & sck_p[2];
  wire sle_r   = sle_p[1] & ~sle_p[2];
  wire scl_hi  = sck_p[1] & sck_p[2];
  wire i_start = mode_two_wire & scl_hi & ~sdi_p[1] & sdi_p[2];
  wire i_stop  = mode_two_wire & scl_hi & sdi_p[1] & ~sdi_p[2];

  // three-wire shifter
  logic [15:0] sr3;
  logic [4:0]  n3;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr3 <= '0;
      n3  <= '0;
    end else if (!mode_two_wire) begin
      if (sle_r) n3 <= '0;
      else if (!sle_p[1] && sck_r) begin
        sr3 <= {sr3[14:0], sdi_p[1]};
        if (n3 != 5'd17) n3 <= n3 + 5'd1;
      end
    end
  wire c3 = !mode_two_wire && sle_r && (n3 == 5'd16);

  // two-wire target
  ist_t        st;
  logic [7:0]  sr2, hi2;
  logic [3:0]  n2;
  logic [15:0] w2;
  logic        c2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= I_IDLE; sr2 <= '0; hi2 <= '0; n2 <= '0; w2 <= '0; c2 <= 1'b0; sda_pull <= 1'b0;
    end else begin
      c2 <= 1'b0;
      if (!mode_two_wire) begin
        st <= I_IDLE;
        sda_pull <= 1'b0;
      end else if (i_start) begin
        st <= I_ADDR; n2 <= '0; sda_pull <= 1'b0;
      end else if (i_stop) begin
        st <= I_IDLE; sda_pull <= 1'b0;
      end else if (sck_r && (st == I_ADDR || st == I_HI || st == I_LO)) begin
        sr2 <= {sr2[6:0], sdi_p[1]};
        n2  <= n2 + 4'd1;
      end else if (sck_f) begin
        case (st)
          I_ADDR: if (n2 == 4'd8) begin
            n2 <= '0;
            if (sr2 == {DEV_ADDR, 1'b0}) begin sda_pull <= 1'b1; st <= I_ACKA; end
            else st <= I_SKIP;
          end
          I_HI: if (n2 == 4'd8) begin
            n2 <= '0; hi2 <= sr2; sda_pull <= 1'b1; st <= I_ACKH;
          end
          I_LO: if (n2 == 4'd8) begin
            n2 <= '0; w2 <= {hi2, sr2}; c2 <= 1'b1; sda_pull <= 1'b1; st <= I_ACKL;
          end
          I_ACKA: begin sda_pull <= 1'b0; st <= I_HI; end
          I_ACKH: begin sda_pull <= 1'b0; st <= I_LO; end
          I_ACKL: begin sda_pull <= 1'b0; st <= I_SKIP; end
          default: ;
        endcase
      end
    end

  // commit decode
  wire        cm  = c3 | c2;
  wire [15:0] cw  = mode_two_wire ? w2 : sr3;
  wire [6:0]  ca  = cw[15:9];
  wire [8:0]  dat = cw[8:0];
  wire        srst = cm && (ca == 7'd0);
  wire        in_range = int'(ca) < NREG;

  logic [NPAIR-1:0] in_pair;
  always_comb
    for (int k = 0; k < NPAIR; k++)
      in_pair[k] = (ca == PAIR_MAP[k*14 +: 7]) || (ca == PAIR_MAP[k*14+7 +: 7]);
  wire is_vol = |in_pair;

  // free-running timeout tick
  logic [TW-1:0] tcnt;
  wire tick = (tcnt == TW'(TMO_CYC - 1));
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else tcnt <= tick ? '0 : tcnt + 1'b1;

  // register bank, shadows and pending updates
  logic [8:0] act [NREG];
  logic [7:0] shd [NREG];
  logic [NPAIR-1:0] pend, now, seen, apply;

  always_comb
    for (int k = 0; k < NPAIR; k++)
      apply[k] = pend[k] & (now[k] | zc_in[k] | (tick & seen[k]));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        act[i] <= RST_VALS[i*9 +: 9];
        shd[i] <= RST_VALS[i*9 +: 8];
      end
      pend <= '0; now <= '0; seen <= '0; upd_stb <= '0;
    end else if (srst) begin
      for (int i = 0; i < NREG; i++) begin
        act[i] <= RST_VALS[i*9 +: 9];
        shd[i] <= RST_VALS[i*9 +: 8];
      end
      pend <= '0; now <= '0; seen <= '0; upd_stb <= '0;
    end else begin
      upd_stb <= apply;
      for (int k = 0; k < NPAIR; k++) begin
        if (apply[k]) begin
          act[AW'(PAIR_MAP[k*14 +: 7])]   <= {1'b0, shd[AW'(PAIR_MAP[k*14 +: 7])]};
          act[AW'(PAIR_MAP[k*14+7 +: 7])] <= {1'b0, shd[AW'(PAIR_MAP[k*14+7 +: 7])]};
          pend[k] <= 1'b0;
        end else if (pend[k] && tick) seen[k] <= 1'b1;
      end
      if (cm && in_range) begin
        if (is_vol) begin
          shd[AW'(ca)] <= dat[7:0];
          for (int k = 0; k < NPAIR; k++)
            if (in_pair[k] && dat[8]) begin
              pend[k] <= 1'b1;
              now[k]  <= ~dat[7];
              seen[k] <= 1'b0;
            end
        end else act[AW'(ca)] <= dat;
      end
    end

  always_comb
    for (int i = 0; i < NREG; i++) reg_q[i*9 +: 9] = act[i];
endmodule

// File: rtl/serctl_regfile_chk.sv
`timescale 1ns/1ps
module serctl_regfile_chk #(
  parameter int NREG = 16,
  parameter int NPAIR = 2,
  parameter logic [NPAIR*14-1:0] PAIR_MAP = {7'd7, 7'd6, 7'd5, 7'd4}
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_two_wire,
  input logic              sda_pull,
  input logic [NPAIR-1:0]  upd_stb,
  input logic [NREG*9-1:0] reg_q,
  input logic [NPAIR-1:0]  pend,
  input logic              srst
);
  p_no_pull_threewire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_two_wire |=> !sda_pull);

  p_srst_cancels_r6: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (pend == '0) && (upd_stb == '0));

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    localparam int LA = int'(PAIR_MAP[k*14 +: 7]);
    localparam int RA = int'(PAIR_MAP[k*14+7 +: 7]);

    p_stb_needs_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb[k] |-> $past(pend[k]));

    p_left_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_stb[k] && !$past(srst)) |-> $stable(reg_q[LA*9 +: 9]));

    p_right_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_stb[k] && !$past(srst)) |-> $stable(reg_q[RA*9 +: 9]));
  end
endmodule

bind serctl_regfile serctl_regfile_chk #(.NREG(NREG), .NPAIR(NPAIR), .PAIR_MAP(PAIR_MAP)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_two_wire(mode_two_wire), .sda_pull(sda_pull),
  .upd_stb(upd_stb), .reg_q(reg_q), .pend(pend), .srst(srst)
);

// File: tb/serctl_regfile_tb_top.sv
`timescale 1ns/1ps
module serctl_regfile_tb_top;
  localparam int NREG = 16;
  localparam int NPAIR = 2;
  localparam int TMO = 400;
  localparam logic [7:0] ADDR_W = {7'b0011010, 1'b0};

  function automatic logic [8:0] dv(int k);
    return 9'((k * 29 + 11) % 256);
  endfunction
  function automatic logic [NREG*9-1:0] mkdef();
    logic [NREG*9-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*9 +: 9] = dv(k);
    return v;
  endfunction
  localparam logic [NREG*9-1:0] DEFS = mkdef();

  // {mode, addr, data}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 7'd1,  9'h1A5}, {1'b0, 7'd9,  9'h0F0}, {1'b1, 7'd2, 9'h133},
    {1'b1, 7'd14, 9'h04C}, {1'b0, 7'd15, 9'h1FF}, {1'b1, 7'd3, 9'h000}};

  logic clk = 0, rst_n = 0, mode = 0, sck = 0, din = 0, sle = 1;
  logic [NPAIR-1:0] zc = '0;
  logic sda_pull;
  logic [NPAIR-1:0] upd_stb;
  logic [NREG*9-1:0] reg_q;
  wire sdi = din & ~sda_pull;

  serctl_regfile #(.NREG(NREG), .NPAIR(NPAIR), .TMO_CYC(TMO), .RST_VALS(DEFS)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_two_wire(mode), .sck(sck), .sdi(sdi), .sle(sle),
    .zc_in(zc), .sda_pull(sda_pull), .upd_stb(upd_stb), .reg_q(reg_q));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, pull3 = 0, t0 = 0;
  int stb_cnt [NPAIR];
  int stb_at  [NPAIR];
  initial for (int k = 0; k < NPAIR; k++) begin stb_cnt[k] = 0; stb_at[k] = 0; end

  always @(posedge clk) begin
    cyc++;
    if (!mode && sda_pull) pull3++;
    for (int k = 0; k < NPAIR; k++) if (upd_stb[k]) begin stb_cnt[k]++; stb_at[k] = cyc; end
  end

  function automatic logic [8:0] rd(int a);
    return reg_q[a*9 +: 9];
  endfunction

  task automatic chk(string rq, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, got, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi(logic [16:0] v, int nb);
    sle = 0; w(4);
    for (int i = nb - 1; i >= 0; i--) begin
      din = v[i]; w(4); sck = 1; w(4); sck = 0;
    end
    w(4); sle = 1; t0 = cyc; w(12);
  endtask

  task automatic i2c_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      din = b[i]; w(4); sck = 1; w(4); sck = 0;
    end
    din = 1; w(6); sck = 1; w(2); ack = !sdi; w(2); sck = 0; w(4);
  endtask

  task automatic i2c_wr(logic [7:0] a8, logic [15:0] wd, output logic [2:0] acks);
    din = 1; sck = 1; w(4); din = 0; w(4); sck = 0; w(4);
    i2c_byte(a8, acks[2]);
    i2c_byte(wd[15:8], acks[1]);
    i2c_byte(wd[7:0], acks[0]);
    din = 0; w(4); sck = 1; w(4); din = 1; w(12);
  endtask

  task automatic set_mode(logic m);
    if (m) begin sle = 1; sck = 1; din = 1; w(4); mode = 1; end
    else begin mode = 0; w(2); sck = 0; din = 0; sle = 1; end
    w(8);
  endtask

  task automatic wr(logic [6:0] a, logic [8:0] d);
    logic [2:0] acks;
    if (mode) i2c_wr(ADDR_W, {a, d}, acks);
    else spi({1'b0, a, d}, 16);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic ok;
    w(5); rst_n = 1; w(5);

    // R12 reset state
    ok = 1;
    for (int i = 0; i < NREG; i++) if (rd(i) !== dv(i)) ok = 0;
    chk("R12 defaults", ok, 1);
    chk("R12 outputs idle", {upd_stb, sda_pull}, 0);

    // R1 / R3 vector walk
    for (int v = 0; v < 6; v++) begin
      set_mode(VEC[v][16]);
      if (VEC[v][16]) begin
        i2c_wr(ADDR_W, {VEC[v][15:9], VEC[v][8:0]}, acks);
        chk("R3 acks", acks, 3'b111);
        chk("R3 write", rd(VEC[v][15:9]), VEC[v][8:0]);
      end else begin
        spi({1'b0, VEC[v][15:0]}, 16);
        chk("R1 write", rd(VEC[v][15:9]), VEC[v][8:0]);
      end
    end

    // R2 short and long frames
    set_mode(0);
    spi({2'b00, 6'd8, 9'h123}, 15);
    chk("R2 short frame", rd(8), dv(8));
    spi({1'b1, 7'd8, 9'h0EE}, 17);
    chk("R2 long frame", rd(8), dv(8));

    // R11 out of range address
    spi({1'b0, 7'd40, 9'h155}, 16);
    chk("R11 high address", rd(8), dv(8));

    // R5 two-wire traffic in three-wire mode
    i2c_wr(ADDR_W, {7'd10, 9'h0AB}, acks);
    chk("R5 2w ignored in 3w", rd(10), dv(10));
    chk("R5 no pull in 3w", pull3, 0);

    // R4 wrong address and read request
    set_mode(1);
    i2c_wr({7'b0011011, 1'b0}, {7'd11, 9'h0CD}, acks);
    chk("R4 foreign addr ack", acks, 3'b000);
    chk("R4 foreign addr write", rd(11), dv(11));
    i2c_wr({7'b0011010, 1'b1}, {7'd11, 9'h0CD}, acks);
    chk("R4 read ack", acks, 3'b000);
    chk("R4 read write", rd(11), dv(11));

    // R5 three-wire frame in two-wire mode
    sck = 0; w(4);
    spi({1'b0, 7'd12, 9'h0DE}, 16);
    din = 1; w(4); sck = 1; w(8);
    chk("R5 3w ignored in 2w", rd(12), dv(12));

    // R7 / R8 immediate pair update
    set_mode(0);
    spi({1'b0, 7'd4, 9'h03C}, 16);
    chk("R7 no update left", rd(4), dv(4));
    spi({1'b0, 7'd5, 9'h155}, 16);
    chk("R8 left applied", rd(4), 9'h03C);
    chk("R8 right applied bit8 clear", rd(5), 9'h055);
    chk("R8 strobe pair0", stb_cnt[0], 1);
    chk("R8 no strobe pair1", stb_cnt[1], 0);

    // R9 zero-crossing gated
    spi({1'b0, 7'd6, 9'h02A}, 16);
    spi({1'b0, 7'd7, 9'h191}, 16);
    chk("R9 waits for crossing", rd(7), dv(7));
    zc[1] = 1; w(1); zc[1] = 0; w(3);
    chk("R9 left on crossing", rd(6), 9'h02A);
    chk("R9 right on crossing", rd(7), 9'h091);
    chk("R9 strobe pair1", stb_cnt[1], 1);

    // R10 timeout fallback
    spi({1'b0, 7'd4, 9'h010}, 16);
    spi({1'b0, 7'd5, 9'h1A2}, 16);
    for (int i = 0; i < 3 * TMO && stb_cnt[0] == 1; i++) w(1);
    chk("R10 latency window", (stb_at[0] - t0 >= TMO) && (stb_at[0] - t0 <= 2 * TMO + 8), 1);
    chk("R10 values", {rd(4), rd(5)}, {9'h010, 9'h0A2});

    // R6 soft reset cancels pending request
    spi({1'b0, 7'd5, 9'h1C7}, 16);
    spi({1'b0, 7'd0, 9'h000}, 16);
    ok = 1;
    for (int i = 0; i < NREG; i++) if (rd(i) !== dv(i)) ok = 0;
    chk("R6 all defaults", ok, 1);
    zc[0] = 1; w(1); zc[0] = 0;
    w(2 * TMO + 20);
    chk("R6 pending cancelled", stb_cnt[0], 2);
    chk("R6 pair stays default", rd(5), dv(5));

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule